// File: doc/BRIEF.md
# Emulated UART Event Interrupt Register

A local microprocessor that imitates a UART in firmware has to learn which register the host side has just touched. This block keeps one pending flag per host access event. A flag is raised by the host-side access and lowered by the matching access on the local side. Each flag is masked by its own enable bit. The enabled flags then compete through a fixed-priority daisy chain to raise an interrupt request toward the local processor.

During an interrupt acknowledge cycle, the winning source is marked as under service. That mark keeps the source, and every source below it, from requesting again. The local processor ends its service routine by writing a 1 to the summary bit of the status byte. This retires only the highest-priority source that is still under service, so nested service unwinds from the top. The chain enable input and output let several such blocks be cascaded.

Top module: `uart_evt_irq`

## Requirements
- R1: After reset, `status_o` is 0 and `irq_o` is 0, and `chain_en_o` equals `chain_en_i`.
- R2: Each source has a fixed bit in `status_o`, set one cycle after its event. The bits and events are:
  - bit 6: `host_thr_wr_i`
  - bit 5: `tx_timeout_i`
  - bit 4: `host_rbr_rd_i`
  - bit 3: `host_mcr_wr_i`
  - bit 2: `host_lcr_wr_i`
  - bit 1: `host_dll_wr_i` or `host_dlm_wr_i`
  - bit 0: `host_fcr_wr_i`
- R3: Each flag clears one cycle after the opposite-side access to its register. The clearing accesses are:
  - bit 6: `local_thr_rd_i`
  - bit 5: `tx_fifo_access_i`
  - bit 4: `local_rbr_wr_i`
  - bit 3: `local_mcr_rd_i`
  - bit 2: `local_lcr_rd_i`
  - bit 0: `local_fcr_rd_i`
- R4: A pulse on `tx_overrun_i` also sets bit 0.
- R5: Bit 1 stays set until each divisor byte written since it was last read has been read. Reading one byte does not clear a pending write to the other byte.
- R6: When a set event and a clear event reach the same flag in one cycle, the flag ends up set.
- R7: `status_o[7]` is the OR of all per-source under-service bits.
- R8: A source is requesting when its flag and its bit of `src_en_i` are both set. On `int_ack_i`, the under-service bit is set for the highest-priority requesting source that is not itself under service and has no requesting or in-service source above it, provided `chain_en_i` is 1. Otherwise nothing changes. Bit 6 has the highest priority and bit 0 the lowest.
- R9: A cycle with `retire_wr_i` and `retire_bit_i`=1 clears only the highest-priority under-service bit. With `retire_bit_i`=0 it has no effect.
- R10: `irq_o` is 1 exactly when `chain_en_i` is 1 and some requesting source is not under service and has no requesting or in-service source above it.
- R11: `chain_en_o` is 1 exactly when `chain_en_i` is 1 and no source is requesting or under service.
- R12: A source whose enable bit is 0 neither requests nor blocks lower sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_thr_wr_i | input | 1 | Host wrote transmit holding register |
| local_thr_rd_i | input | 1 | Local read of transmit holding register |
| tx_timeout_i | input | 1 | Transmit data idle timeout event |
| tx_fifo_access_i | input | 1 | Transmit FIFO read or written |
| host_rbr_rd_i | input | 1 | Host read receive buffer |
| local_rbr_wr_i | input | 1 | Local write of receive buffer |
| host_mcr_wr_i | input | 1 | Host wrote modem control |
| local_mcr_rd_i | input | 1 | Local read of modem control |
| host_lcr_wr_i | input | 1 | Host wrote line control |
| local_lcr_rd_i | input | 1 | Local read of line control |
| host_dll_wr_i | input | 1 | Host wrote divisor low byte |
| host_dlm_wr_i | input | 1 | Host wrote divisor high byte |
| local_dll_rd_i | input | 1 | Local read of divisor low byte |
| local_dlm_rd_i | input | 1 | Local read of divisor high byte |
| host_fcr_wr_i | input | 1 | Host wrote FIFO control |
| tx_overrun_i | input | 1 | Transmit overrun event |
| local_fcr_rd_i | input | 1 | Local read of FIFO control |
| src_en_i | input | 7 | Per-source enable mask |
| chain_en_i | input | 1 | Incoming daisy chain enable |
| int_ack_i | input | 1 | Interrupt acknowledge strobe |
| retire_wr_i | input | 1 | Local write to status summary bit |
| retire_bit_i | input | 1 | Value written to summary bit |
| status_o | output | 8 | Under-service summary and pending flags |
| irq_o | output | 1 | Interrupt request |
| chain_en_o | output | 1 | Outgoing daisy chain enable |

## Verification
The assertions take for granted that every input is a known value that only changes between clock edges. They also assume that each strobe means one event for each cycle it is high. The acknowledge property further assumes that the enable mask and chain input do not move in the cycle of the acknowledge. The stimulus drives all inputs a nanosecond after the rising edge and holds each strobe for exactly one cycle. It changes the mask and chain input only while no acknowledge is in flight. It empties every flag and under-service bit through the normal clear paths before each new pattern.

// File: rtl/uart_evt_pkg.sv
package uart_evt_pkg;
  localparam int unsigned NUM_SRC = 7;
  localparam int unsigned STAT_W  = NUM_SRC + 1;
  // bit positions are the priority order: higher index wins
  localparam int unsigned SRC_THR = 6;
  localparam int unsigned SRC_TMO = 5;
  localparam int unsigned SRC_RBR = 4;
  localparam int unsigned SRC_MCR = 3;
  localparam int unsigned SRC_LCR = 2;
  localparam int unsigned SRC_DIV = 1;
  localparam int unsigned SRC_FCR = 0;
  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/uart_evt_flags.sv
module uart_evt_flags
  import uart_evt_pkg::*;
#(
  parameter int unsigned N   = NUM_SRC,
  parameter int unsigned DIV = SRC_DIV
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         div_lo_set_i,
  input  logic         div_hi_set_i,
  input  logic         div_lo_clr_i,
  input  logic         div_hi_clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    if (g == DIV) begin : g_div
      logic lo_q, hi_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          lo_q <= 1'b0;
          hi_q <= 1'b0;
        end else begin
          lo_q <= (lo_q & ~div_lo_clr_i) | div_lo_set_i;
          hi_q <= (hi_q & ~div_hi_clr_i) | div_hi_set_i;
        end
      end
      assign pend_o[g] = lo_q | hi_q;
    end else begin : g_std
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b0;
        else         q <= (q & ~clr_i[g]) | set_i[g];
      end
      assign pend_o[g] = q;
    end
  end
endmodule

// File: rtl/uart_evt_chain.sv
module uart_evt_chain #(
  parameter int unsigned N = 7
) (
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] ius_i,
  input  logic         chain_en_i,
  output logic [N-1:0] win_o,
  output logic         irq_o,
  output logic         chain_en_o
);
  // en[k] is the enable leaving stage k; en[N] is the chain input
  logic [N:0] en;
  assign en[N] = chain_en_i;
  for (genvar g = N - 1; g >= 0; g--) begin : g_stage
    assign en[g]    = en[g+1] & ~(req_i[g] | ius_i[g]);
    assign win_o[g] = en[g+1] & req_i[g] & ~ius_i[g];
  end
  assign irq_o      = |win_o;
  assign chain_en_o = en[0];
endmodule

// File: rtl/uart_evt_ius.sv
module uart_evt_ius #(
  parameter int unsigned N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ack_i,
  input  logic [N-1:0] win_i,
  input  logic         retire_i,
  output logic [N-1:0] ius_o
);
  logic [N-1:0] ius_q, top_set;
  logic [N:0]   above;

  assign above[N] = 1'b0;
  for (genvar g = N - 1; g >= 0; g--) begin : g_top
    assign above[g]   = above[g+1] | ius_q[g];
    assign top_set[g] = ius_q[g] & ~above[g+1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ius_q <= '0;
    else ius_q <= (ius_q & ~(top_set & {N{retire_i}})) | (win_i & {N{ack_i}});
  end

  assign ius_o = ius_q;
endmodule

// File: rtl/uart_evt_irq.sv
module uart_evt_irq
  import uart_evt_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_thr_wr_i,
  input  logic               local_thr_rd_i,
  input  logic               tx_timeout_i,
  input  logic               tx_fifo_access_i,
  input  logic               host_rbr_rd_i,
  input  logic               local_rbr_wr_i,
  input  logic               host_mcr_wr_i,
  input  logic               local_mcr_rd_i,
  input  logic               host_lcr_wr_i,
  input  logic               local_lcr_rd_i,
  input  logic               host_dll_wr_i,
  input  logic               host_dlm_wr_i,
  input  logic               local_dll_rd_i,
  input  logic               local_dlm_rd_i,
  input  logic               host_fcr_wr_i,
  input  logic               tx_overrun_i,
  input  logic               local_fcr_rd_i,
  input  logic [NUM_SRC-1:0] src_en_i,
  input  logic               chain_en_i,
  input  logic               int_ack_i,
  input  logic               retire_wr_i,
  input  logic               retire_bit_i,
  output logic [STAT_W-1:0]  status_o,
  output logic               irq_o,
  output logic               chain_en_o
);
  src_vec_t set_v, clr_v, pend, req, win, ius;

  always_comb begin
    set_v = '0;
    clr_v = '0;
    set_v[SRC_THR] = host_thr_wr_i;
    clr_v[SRC_THR] = local_thr_rd_i;
    set_v[SRC_TMO] = tx_timeout_i;
    clr_v[SRC_TMO] = tx_fifo_access_i;
    set_v[SRC_RBR] = host_rbr_rd_i;
    clr_v[SRC_RBR] = local_rbr_wr_i;
    set_v[SRC_MCR] = host_mcr_wr_i;
    clr_v[SRC_MCR] = local_mcr_rd_i;
    set_v[SRC_LCR] = host_lcr_wr_i;
    clr_v[SRC_LCR] = local_lcr_rd_i;
    set_v[SRC_FCR] = host_fcr_wr_i | tx_overrun_i;
    clr_v[SRC_FCR] = local_fcr_rd_i;
  end

  uart_evt_flags #(.N(NUM_SRC), .DIV(SRC_DIV)) u_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .set_i        (set_v),
    .clr_i        (clr_v),
    .div_lo_set_i (host_dll_wr_i),
    .div_hi_set_i (host_dlm_wr_i),
    .div_lo_clr_i (local_dll_rd_i),
    .div_hi_clr_i (local_dlm_rd_i),
    .pend_o       (pend)
  );

  assign req = pend & src_en_i;

  uart_evt_chain #(.N(NUM_SRC)) u_chain (
    .req_i      (req),
    .ius_i      (ius),
    .chain_en_i (chain_en_i),
    .win_o      (win),
    .irq_o      (irq_o),
    .chain_en_o (chain_en_o)
  );

  uart_evt_ius #(.N(NUM_SRC)) u_ius (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ack_i    (int_ack_i),
    .win_i    (win),
    .retire_i (retire_wr_i & retire_bit_i),
    .ius_o    (ius)
  );

  assign status_o = {|ius, pend};
endmodule

// File: rtl/uart_evt_irq_chk.sv
module uart_evt_irq_chk
  import uart_evt_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               host_thr_wr_i,
  input logic               host_mcr_wr_i,
  input logic               host_dll_wr_i,
  input logic               tx_overrun_i,
  input logic [NUM_SRC-1:0] src_en_i,
  input logic               chain_en_i,
  input logic               int_ack_i,
  input logic               retire_wr_i,
  input logic               retire_bit_i,
  input logic [STAT_W-1:0]  status_o,
  input logic               irq_o,
  input logic               chain_en_o
);
  assert_thr_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_thr_wr_i |=> status_o[6]);
  assert_overrun_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_overrun_i |=> status_o[0]);
  assert_div_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_dll_wr_i |=> status_o[1]);
  assert_set_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_mcr_wr_i |=> status_o[3]);
  assert_ack_marks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_ack_i && irq_o) |=> status_o[7]);
  assert_retire_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_wr_i && !retire_bit_i && !int_ack_i) |=> $stable(status_o[7]));
  assert_irq_blocks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !chain_en_o);
  assert_chain_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chain_en_i |-> (!chain_en_o && !irq_o));
  assert_mask_off_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_en_i == '0) |-> !irq_o);
endmodule

bind uart_evt_irq uart_evt_irq_chk u_chk (.*);

// File: tb/sim_uart_evt_irq.sv
`timescale 1ns/1ps
module sim_uart_evt_irq;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic host_thr_wr, local_thr_rd, tx_timeout, tx_fifo_access, host_rbr_rd, local_rbr_wr;
  logic host_mcr_wr, local_mcr_rd, host_lcr_wr, local_lcr_rd, host_dll_wr, host_dlm_wr;
  logic local_dll_rd, local_dlm_rd, host_fcr_wr, tx_overrun, local_fcr_rd;
  logic [6:0] src_en;
  logic chain_en, int_ack, retire_wr, retire_bit;
  logic [7:0] status;
  logic irq, chain_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_evt_irq u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .host_thr_wr_i(host_thr_wr), .local_thr_rd_i(local_thr_rd),
    .tx_timeout_i(tx_timeout), .tx_fifo_access_i(tx_fifo_access),
    .host_rbr_rd_i(host_rbr_rd), .local_rbr_wr_i(local_rbr_wr),
    .host_mcr_wr_i(host_mcr_wr), .local_mcr_rd_i(local_mcr_rd),
    .host_lcr_wr_i(host_lcr_wr), .local_lcr_rd_i(local_lcr_rd),
    .host_dll_wr_i(host_dll_wr), .host_dlm_wr_i(host_dlm_wr),
    .local_dll_rd_i(local_dll_rd), .local_dlm_rd_i(local_dlm_rd),
    .host_fcr_wr_i(host_fcr_wr), .tx_overrun_i(tx_overrun),
    .local_fcr_rd_i(local_fcr_rd), .src_en_i(src_en),
    .chain_en_i(chain_en), .int_ack_i(int_ack),
    .retire_wr_i(retire_wr), .retire_bit_i(retire_bit),
    .status_o(status), .irq_o(irq), .chain_en_o(chain_out)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    {host_thr_wr, local_thr_rd, tx_timeout, tx_fifo_access, host_rbr_rd, local_rbr_wr,
     host_mcr_wr, local_mcr_rd, host_lcr_wr, local_lcr_rd, host_dll_wr, host_dlm_wr,
     local_dll_rd, local_dlm_rd, host_fcr_wr, tx_overrun, local_fcr_rd} = '0;
    {int_ack, retire_wr, retire_bit} = '0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic set_flags(input logic [6:0] m);
    host_thr_wr = m[6]; tx_timeout = m[5]; host_rbr_rd = m[4]; host_mcr_wr = m[3];
    host_lcr_wr = m[2]; host_dll_wr = m[1]; host_fcr_wr = m[0];
    tick();
  endtask

  task automatic clear_all();
    local_thr_rd = 1; tx_fifo_access = 1; local_rbr_wr = 1; local_mcr_rd = 1;
    local_lcr_rd = 1; local_dll_rd = 1; local_dlm_rd = 1; local_fcr_rd = 1;
    tick();
    for (int k = 0; k < 7; k++) begin
      retire_wr = 1; retire_bit = 1;
      tick();
    end
  endtask

  task automatic retire();
    retire_wr = 1; retire_bit = 1;
    tick();
  endtask

  task automatic ack();
    int_ack = 1;
    tick();
  endtask

  function automatic int hb(input logic [6:0] m);
    for (int k = 6; k >= 0; k--) if (m[k]) return k;
    return -1;
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [6:0] ie2;
    idle();
    src_en = 7'h7f; chain_en = 1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 status", status, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 chain", {7'b0, chain_out}, 8'h01);
    rst_ni = 1;
    tick();

    // R2/R10/R11/R12 sweep: every flag pattern x every mask x chain in
    for (int m = 0; m < 128; m++) begin
      clear_all();
      set_flags(7'(m));
      chk("R2 flags", status, {1'b0, 7'(m)});
      for (int e = 0; e < 128; e++) begin
        for (int c = 0; c < 2; c++) begin
          src_en = 7'(e); chain_en = c[0];
          #0.1;
          chk("R10 irq", {7'b0, irq}, {7'b0, c[0] && ((7'(m) & 7'(e)) != 0)});
          chk("R11 R12 chain", {7'b0, chain_out}, {7'b0, c[0] && ((7'(m) & 7'(e)) == 0)});
        end
      end
      src_en = 7'h7f; chain_en = 1;
      #0.1;
    end

    // R8/R9/R7 acknowledge sweep with the top requester masked off
    for (int m = 1; m < 128; m++) begin
      clear_all();
      set_flags(7'(m));
      ie2 = 7'h7f & ~(7'(1) << hb(7'(m)));
      src_en = ie2;
      ack();
      chk("R8 R7 ack", {7'b0, status[7]}, {7'b0, (7'(m) & ie2) != 0});
      src_en = 7'h7f;
      #0.1;
      chk("R10 top above ius", {7'b0, irq}, 8'h01);
      ack();
      chk("R8 ack top", {7'b0, status[7]}, 8'h01);
      chk("R10 all served", {7'b0, irq}, 8'h00);
      chk("R11 served blocks", {7'b0, chain_out}, 8'h00);
    end

    // R8 no ack when chain input is low
    clear_all();
    set_flags(7'h10);
    chain_en = 0;
    ack();
    chk("R8 chain low", {7'b0, status[7]}, 8'h00);
    chain_en = 1;
    #0.1;

    // R9 nested retire
    clear_all();
    set_flags(7'h04);
    ack();
    set_flags(7'h20);
    chk("R10 nested irq", {7'b0, irq}, 8'h01);
    ack();
    chk("R7 two ius", status, 8'ha4);
    retire_wr = 1; retire_bit = 0;
    tick();
    chk("R9 zero no effect irq", {7'b0, irq}, 8'h00);
    chk("R9 zero no effect stat", status, 8'ha4);
    retire();
    chk("R9 only top retired", {7'b0, irq}, 8'h01);
    chk("R9 low still served", {7'b0, status[7]}, 8'h01);
    tx_fifo_access = 1;
    tick();
    chk("R3 timeout cleared", status, 8'h84);
    chk("R9 low blocks", {7'b0, irq}, 8'h00);
    retire();
    chk("R9 all retired", status, 8'h04);
    chk("R10 reissue", {7'b0, irq}, 8'h01);

    // R3 each clear path individually
    clear_all();
    set_flags(7'h7f);
    local_thr_rd = 1; tick(); chk("R3 thr", status, 8'h3f);
    local_rbr_wr = 1; tick(); chk("R3 rbr", status, 8'h2f);
    local_mcr_rd = 1; tick(); chk("R3 mcr", status, 8'h27);
    local_lcr_rd = 1; tick(); chk("R3 lcr", status, 8'h23);
    local_fcr_rd = 1; tick(); chk("R3 fcr", status, 8'h22);
    tx_fifo_access = 1; tick(); chk("R3 tmo", status, 8'h02);

    // R4 overrun
    clear_all();
    tx_overrun = 1; tick();
    chk("R4 overrun", status, 8'h01);

    // R5 divisor bytes
    clear_all();
    host_dll_wr = 1; host_dlm_wr = 1; tick();
    chk("R5 both", status, 8'h02);
    local_dll_rd = 1; tick();
    chk("R5 low read only", status, 8'h02);
    local_dlm_rd = 1; tick();
    chk("R5 both read", status, 8'h00);
    host_dlm_wr = 1; tick();
    local_dll_rd = 1; tick();
    chk("R5 wrong byte read", status, 8'h02);
    local_dlm_rd = 1; tick();
    chk("R5 high read", status, 8'h00);

    // R6 set wins
    clear_all();
    host_mcr_wr = 1; local_mcr_rd = 1; tick();
    chk("R6 set wins", status, 8'h08);
    host_dll_wr = 1; local_dll_rd = 1; tick();
    chk("R6 set wins div", status, 8'h0a);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule